// File: doc/BRIEF.md
# Page Coherence Directory Entry Controller

This block holds the coherence record of every page in a small on-chip directory. The record covers a fixed set of processors. Each processor has its own request port and can report one of four events for a page: a read access fault, a write access fault, a release, or an unmap. One request is granted per cycle, in round-robin order among the ports that may proceed. The granted request updates the page's record, and the new record is returned on a single response port. The response tells the requester which other processors must receive write notices.

Each record holds several fields. There is a sharing state (uncached, shared, dirty or weak). Two bitmaps list the processors that map the page and the processors that may write it. A further bitmap lists writers whose weak transition is postponed. A saturating counter counts how often the page has turned weak. A sticky unsafe flag is set once the page has turned weak often enough; an unsafe page turns weak silently and produces no write notices. A mode input selects delayed transitions. In that mode, a write to a page that other processors still read leaves the page shared until the writer releases.

Requests flow through three stages: accept, entry read, then update and respond. Because the entry read is registered, a request to the page accepted in the previous cycle is held off at its port. This keeps updates to one page in arrival order.

Top module: `page_coherence_dir`

## Requirements
- R1: After reset every page is uncached, safe, with empty bitmaps and a zero weak count, and rsp_valid is low. State codes on rsp_state: 0 uncached, 1 shared, 2 dirty, 3 weak. Op codes on req_op: 0 read fault, 1 write fault, 2 release, 3 unmap.
- R2: A read fault adds the requester to the mappers. An uncached page becomes shared. A shared or weak page keeps its state. None of these cases produces notices.
- R3: A write fault by a processor that is the only mapper, or that maps a page nobody else maps, makes the page dirty with no notices.
- R4: A safe page turns weak in three cases: a write fault on a shared page with other mappers (immediate mode), a write fault on a dirty page owned by another processor, or a read fault on a dirty page owned by another processor. In each case rsp_notice lists every other mapper. Bit i of rsp_notice stands for processor i.
- R5: The weak count saturates at UNSAFE_AFTER (default 2). A transition to weak that starts with the count already at UNSAFE_AFTER sets the unsafe flag and gives an all-zero notice map. The flag never clears, and an unsafe page never produces notices.
- R6: Any fault on a page that is already weak leaves it weak with no notices.
- R7: With delay_mode high, a write fault on a shared page that has other mappers leaves the page shared with no notices and marks the writer pending. That writer's next release applies the weak transition, with notices as in R4 and R5, or makes the page dirty if no other mapper remains. A release by a processor that is not pending changes nothing.
- R8: An unmap removes the requester from all bitmaps. If no mapper is left the page becomes uncached. If exactly one mapper is left and it is a writer the page becomes dirty. If no writer is left the page becomes shared. Otherwise the state is kept.
- R9: At most one port is granted per cycle, and a grant is given only to a valid port. Among the eligible ports, priority rotates, starting from the port after the last one granted (port 0 first after reset).
- R10: A port whose page equals the page accepted in the previous cycle sees req_ready low for that cycle, while ports with other pages may be granted. Each accepted request yields one response two clock edges after its accept edge, in accept order, carrying rsp_proc and rsp_page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| delay_mode | input | 1 | High: postpone weak transitions of shared pages until the writer releases |
| req_valid | input | NPROC | Request present, one bit per processor port |
| req_ready | output | NPROC | Grant, one bit per port; the request is taken on a clock edge where valid and ready are both high |
| req_page | input | NPROC*PGW | Page index of each port, port i in bits [i*PGW +: PGW] |
| req_op | input | NPROC*2 | Op code of each port, port i in bits [i*2 +: 2] |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_proc | output | PIW | Processor whose request produced the response |
| rsp_page | output | PGW | Page the response describes |
| rsp_state | output | 2 | Sharing state after the update |
| rsp_unsafe | output | 1 | Unsafe flag after the update |
| rsp_notice | output | NPROC | Processors that must receive write notices |

## Verification
The assertions assume that a port keeps its page and op stable while its valid bit is high and its grant is low. They also assume that delay_mode does not change while a request is in flight. The stimulus respects both: each request is driven at a falling edge and held until the edge that grants it, and delay_mode changes only between requests, once the response has arrived. The random phase keeps a single request in flight at a time, on four pages, so pages repeatedly pass through every sharing state and saturate their weak counts. Directed sequences cover simultaneous requests to the same page and to different pages.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  typedef enum logic [1:0] {
    PG_UNCACHED = 2'd0,
    PG_SHARED   = 2'd1,
    PG_DIRTY    = 2'd2,
    PG_WEAK     = 2'd3
  } pg_state_e;

  typedef enum logic [1:0] {
    OP_RD    = 2'd0,
    OP_WR    = 2'd1,
    OP_REL   = 2'd2,
    OP_UNMAP = 2'd3
  } pg_op_e;
endpackage

// File: rtl/pcd_arbiter.sv
module pcd_arbiter #(
  parameter int N   = 4,
  parameter int IW  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [IW-1:0] last_q, last_d;

  always_comb begin
    gnt = '0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = int'(last_q) + k;
      if (idx >= N) idx = idx - N;
      if (gnt == '0 && req[idx]) gnt[idx] = 1'b1;
    end
  end

  always_comb begin
    last_d = last_q;
    for (int j = 0; j < N; j++) begin
      if (gnt[j]) last_d = IW'(j);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= IW'(N - 1);
    else if (gnt != '0) last_q <= last_d;
  end

  assert_onehot_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  assert_grant_requested_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
endmodule

// File: rtl/pcd_update.sv
module pcd_update import pcd_pkg::*; #(
  parameter int NPROC        = 4,
  parameter int PIW          = 2,
  parameter int CW           = 2,
  parameter int UNSAFE_AFTER = 2
) (
  input  logic [NPROC-1:0] map_i,
  input  logic [NPROC-1:0] wr_i,
  input  logic [NPROC-1:0] pend_i,
  input  pg_state_e        st_i,
  input  logic             unsafe_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic [PIW-1:0]   proc_i,
  input  pg_op_e           op_i,
  input  logic             delay_i,
  output logic [NPROC-1:0] map_o,
  output logic [NPROC-1:0] wr_o,
  output logic [NPROC-1:0] pend_o,
  output pg_state_e        st_o,
  output logic             unsafe_o,
  output logic [CW-1:0]    cnt_o,
  output logic [NPROC-1:0] notice_o
);
  logic [NPROC-1:0] me;
  logic             to_weak;

  always_comb begin
    me          = '0;
    me[proc_i]  = 1'b1;
    map_o       = map_i;
    wr_o        = wr_i;
    pend_o      = pend_i;
    st_o        = st_i;
    unsafe_o    = unsafe_i;
    cnt_o       = cnt_i;
    notice_o    = '0;
    to_weak     = 1'b0;
    case (op_i)
      OP_RD: begin
        map_o = map_i | me;
        if (st_i == PG_UNCACHED) st_o = PG_SHARED;
        else if (st_i == PG_DIRTY && (wr_i & ~me) != '0) to_weak = 1'b1;
      end
      OP_WR: begin
        map_o = map_i | me;
        wr_o  = wr_i | me;
        if ((map_i & ~me) == '0) st_o = PG_DIRTY;
        else if (st_i == PG_WEAK) st_o = PG_WEAK;
        else if (delay_i && st_i == PG_SHARED) pend_o = pend_i | me;
        else to_weak = 1'b1;
      end
      OP_REL: begin
        if ((pend_i & me) != '0) begin
          pend_o = pend_i & ~me;
          if (st_i == PG_SHARED) begin
            if ((map_i & ~me) != '0) to_weak = 1'b1;
            else st_o = PG_DIRTY;
          end
        end
      end
      default: begin
        map_o  = map_i & ~me;
        wr_o   = wr_i & ~me;
        pend_o = pend_i & ~me;
        if (map_o == '0) begin
          st_o   = PG_UNCACHED;
          pend_o = '0;
        end else if (((map_o & (map_o - 1'b1)) == '0) && (map_o & wr_o) != '0) begin
          st_o   = PG_DIRTY;
          pend_o = '0;
        end else if (wr_o == '0) begin
          st_o   = PG_SHARED;
          pend_o = '0;
        end
      end
    endcase
    if (to_weak) begin
      st_o = PG_WEAK;
      if (cnt_i >= CW'(UNSAFE_AFTER)) unsafe_o = 1'b1;
      else cnt_o = cnt_i + 1'b1;
      if (!unsafe_o) notice_o = map_o & ~me;
    end
  end
endmodule

// File: rtl/page_coherence_dir.sv
module page_coherence_dir import pcd_pkg::*; #(
  parameter int NPROC        = 4,
  parameter int NPAGE        = 16,
  parameter int UNSAFE_AFTER = 2,
  parameter int PIW          = (NPROC > 1) ? $clog2(NPROC) : 1,
  parameter int PGW          = (NPAGE > 1) ? $clog2(NPAGE) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 delay_mode,
  input  logic [NPROC-1:0]     req_valid,
  output logic [NPROC-1:0]     req_ready,
  input  logic [NPROC*PGW-1:0] req_page,
  input  logic [NPROC*2-1:0]   req_op,
  output logic                 rsp_valid,
  output logic [PIW-1:0]       rsp_proc,
  output logic [PGW-1:0]       rsp_page,
  output logic [1:0]           rsp_state,
  output logic                 rsp_unsafe,
  output logic [NPROC-1:0]     rsp_notice
);
  localparam int CW = $clog2(UNSAFE_AFTER + 1);

  // directory storage
  logic [NPROC-1:0] dir_map  [NPAGE];
  logic [NPROC-1:0] dir_wr   [NPAGE];
  logic [NPROC-1:0] dir_pend [NPAGE];
  pg_state_e        dir_st   [NPAGE];
  logic             dir_uns  [NPAGE];
  logic [CW-1:0]    dir_cnt  [NPAGE];

  // accept stage
  logic [NPROC-1:0] blocked, eligible, gnt;
  logic             acc_valid;
  logic [PIW-1:0]   acc_proc;
  logic [PGW-1:0]   acc_page;
  pg_op_e           acc_op;

  logic             s1_valid;
  logic [PIW-1:0]   s1_proc;
  logic [PGW-1:0]   s1_page;
  pg_op_e           s1_op;

  logic             s2_valid;
  logic [PIW-1:0]   s2_proc;
  logic [PGW-1:0]   s2_page;
  pg_op_e           s2_op;
  logic [NPROC-1:0] s2_map, s2_wr, s2_pend;
  pg_state_e        s2_st;
  logic             s2_uns;
  logic [CW-1:0]    s2_cnt;

  logic [NPROC-1:0] upd_map, upd_wr, upd_pend, upd_notice;
  pg_state_e        upd_st;
  logic             upd_uns;
  logic [CW-1:0]    upd_cnt;

  // a port whose page was taken last cycle must wait: its entry read would be stale
  for (genvar g = 0; g < NPROC; g++) begin : g_hazard
    assign blocked[g] = s1_valid && (req_page[g*PGW +: PGW] == s1_page);
  end
  assign eligible = req_valid & ~blocked;

  pcd_arbiter #(.N(NPROC), .IW(PIW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(eligible), .gnt(gnt)
  );
  assign req_ready = gnt;
  assign acc_valid = |gnt;

  always_comb begin
    acc_proc = '0;
    acc_page = '0;
    acc_op   = OP_RD;
    for (int i = 0; i < NPROC; i++) begin
      if (gnt[i]) begin
        acc_proc = PIW'(i);
        acc_page = req_page[i*PGW +: PGW];
        acc_op   = pg_op_e'(req_op[i*2 +: 2]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_proc  <= '0;
      s1_page  <= '0;
      s1_op    <= OP_RD;
    end else begin
      s1_valid <= acc_valid;
      if (acc_valid) begin
        s1_proc <= acc_proc;
        s1_page <= acc_page;
        s1_op   <= acc_op;
      end
    end
  end

  // registered entry read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_valid <= 1'b0;
      s2_proc  <= '0;
      s2_page  <= '0;
      s2_op    <= OP_RD;
      s2_map   <= '0;
      s2_wr    <= '0;
      s2_pend  <= '0;
      s2_st    <= PG_UNCACHED;
      s2_uns   <= 1'b0;
      s2_cnt   <= '0;
    end else begin
      s2_valid <= s1_valid;
      if (s1_valid) begin
        s2_proc <= s1_proc;
        s2_page <= s1_page;
        s2_op   <= s1_op;
        s2_map  <= dir_map[s1_page];
        s2_wr   <= dir_wr[s1_page];
        s2_pend <= dir_pend[s1_page];
        s2_st   <= dir_st[s1_page];
        s2_uns  <= dir_uns[s1_page];
        s2_cnt  <= dir_cnt[s1_page];
      end
    end
  end

  pcd_update #(.NPROC(NPROC), .PIW(PIW), .CW(CW), .UNSAFE_AFTER(UNSAFE_AFTER)) u_upd (
    .map_i(s2_map), .wr_i(s2_wr), .pend_i(s2_pend), .st_i(s2_st),
    .unsafe_i(s2_uns), .cnt_i(s2_cnt), .proc_i(s2_proc), .op_i(s2_op),
    .delay_i(delay_mode),
    .map_o(upd_map), .wr_o(upd_wr), .pend_o(upd_pend), .st_o(upd_st),
    .unsafe_o(upd_uns), .cnt_o(upd_cnt), .notice_o(upd_notice)
  );

  // write-back
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NPAGE; p++) begin
        dir_map[p]  <= '0;
        dir_wr[p]   <= '0;
        dir_pend[p] <= '0;
        dir_st[p]   <= PG_UNCACHED;
        dir_uns[p]  <= 1'b0;
        dir_cnt[p]  <= '0;
      end
    end else if (s2_valid) begin
      dir_map[s2_page]  <= upd_map;
      dir_wr[s2_page]   <= upd_wr;
      dir_pend[s2_page] <= upd_pend;
      dir_st[s2_page]   <= upd_st;
      dir_uns[s2_page]  <= upd_uns;
      dir_cnt[s2_page]  <= upd_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_proc   <= '0;
      rsp_page   <= '0;
      rsp_state  <= 2'd0;
      rsp_unsafe <= 1'b0;
      rsp_notice <= '0;
    end else begin
      rsp_valid <= s2_valid;
      if (s2_valid) begin
        rsp_proc   <= s2_proc;
        rsp_page   <= s2_page;
        rsp_state  <= upd_st;
        rsp_unsafe <= upd_uns;
        rsp_notice <= upd_notice;
      end
    end
  end

  assert_no_stale_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && s1_valid) |-> (acc_page != s1_page));
  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |=> rsp_valid);
  assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_valid |=> !rsp_valid);
  assert_unsafe_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_uns) |-> upd_uns);
  assert_unsafe_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_unsafe) |-> (rsp_notice == '0));
  assert_uncached_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_state == 2'd0) |-> (rsp_notice == '0));
endmodule

// File: tb/page_coherence_dir_bench.sv
module page_coherence_dir_bench;
  localparam int NPROC = 4;
  localparam int NPAGE = 16;
  localparam int PGW   = 4;
  localparam int PIW   = 2;
  localparam int LIMIT = 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 delay_mode = 1'b0;
  logic [NPROC-1:0]     req_valid = '0;
  logic [NPROC-1:0]     req_ready;
  logic [NPROC*PGW-1:0] req_page = '0;
  logic [NPROC*2-1:0]   req_op = '0;
  logic                 rsp_valid;
  logic [PIW-1:0]       rsp_proc;
  logic [PGW-1:0]       rsp_page;
  logic [1:0]           rsp_state;
  logic                 rsp_unsafe;
  logic [NPROC-1:0]     rsp_notice;

  int checks = 0;
  int errors = 0;
  int last_gnt = NPROC - 1;

  // reference model
  bit [NPROC-1:0] m_map [NPAGE];
  bit [NPROC-1:0] m_wr  [NPAGE];
  bit [NPROC-1:0] m_pnd [NPAGE];
  int             m_st  [NPAGE];
  bit             m_uns [NPAGE];
  int             m_cnt [NPAGE];

  always #2.5 clk = ~clk;

  page_coherence_dir #(.NPROC(NPROC), .NPAGE(NPAGE), .UNSAFE_AFTER(LIMIT)) u_page_coherence_dir (
    .clk(clk), .rst_n(rst_n), .delay_mode(delay_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_page(req_page), .req_op(req_op),
    .rsp_valid(rsp_valid), .rsp_proc(rsp_proc), .rsp_page(rsp_page),
    .rsp_state(rsp_state), .rsp_unsafe(rsp_unsafe), .rsp_notice(rsp_notice)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int onebits(bit [NPROC-1:0] v);
    int n = 0;
    for (int i = 0; i < NPROC; i++) n += v[i];
    return n;
  endfunction

  // returns expected state, unsafe flag and notice map
  task automatic model_apply(int p, int pg, int op, output int st, output bit uns, output int nt);
    bit [NPROC-1:0] me, rest;
    bit weak_evt;
    me = '0; me[p] = 1'b1;
    rest = m_map[pg] & ~me;
    weak_evt = 1'b0;
    nt = 0;
    if (op == 0) begin
      m_map[pg] |= me;
      if (m_st[pg] == 0) m_st[pg] = 1;
      else if (m_st[pg] == 2 && (m_wr[pg] & ~me) != 0) weak_evt = 1'b1;
    end else if (op == 1) begin
      m_map[pg] |= me;
      m_wr[pg]  |= me;
      if (rest == 0) m_st[pg] = 2;
      else if (m_st[pg] == 3) m_st[pg] = 3;
      else if (delay_mode && m_st[pg] == 1) m_pnd[pg] |= me;
      else weak_evt = 1'b1;
    end else if (op == 2) begin
      if ((m_pnd[pg] & me) != 0) begin
        m_pnd[pg] &= ~me;
        if (m_st[pg] == 1) begin
          if (rest != 0) weak_evt = 1'b1;
          else m_st[pg] = 2;
        end
      end
    end else begin
      m_map[pg] &= ~me;
      m_wr[pg]  &= ~me;
      m_pnd[pg] &= ~me;
      if (m_map[pg] == 0) begin
        m_st[pg] = 0; m_pnd[pg] = '0;
      end else if (onebits(m_map[pg]) == 1 && (m_map[pg] & m_wr[pg]) != 0) begin
        m_st[pg] = 2; m_pnd[pg] = '0;
      end else if (m_wr[pg] == 0) begin
        m_st[pg] = 1; m_pnd[pg] = '0;
      end
    end
    if (weak_evt) begin
      m_st[pg] = 3;
      if (m_cnt[pg] >= LIMIT) m_uns[pg] = 1'b1;
      else m_cnt[pg]++;
      if (!m_uns[pg]) nt = int'(m_map[pg] & ~me);
    end
    st = m_st[pg];
    uns = m_uns[pg];
  endtask

  function automatic int rr_pick(bit [NPROC-1:0] mask);
    for (int k = 1; k <= NPROC; k++) begin
      int idx = (last_gnt + k) % NPROC;
      if (mask[idx]) return idx;
    end
    return -1;
  endfunction

  task automatic drive(int p, int pg, int op);
    req_page[p*PGW +: PGW] = PGW'(pg);
    req_op[p*2 +: 2] = 2'(op);
    req_valid[p] = 1'b1;
  endtask

  task automatic check_rsp(string tag, int p, int pg, int st, bit uns, int nt);
    chk({tag, " rsp_valid"}, rsp_valid, 1);
    chk({tag, " rsp_proc"}, rsp_proc, p);
    chk({tag, " rsp_page"}, rsp_page, pg);
    chk({tag, " state"}, rsp_state, st);
    chk({tag, " unsafe"}, rsp_unsafe, uns);
    chk({tag, " notice"}, rsp_notice, nt);
  endtask

  // one request alone in flight
  task automatic do_req(string tag, int p, int pg, int op);
    int st, nt;
    bit uns;
    @(negedge clk);
    drive(p, pg, op);
    #1;
    while (!req_ready[p]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    req_valid[p] = 1'b0;
    last_gnt = p;
    model_apply(p, pg, op, st, uns, nt);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check_rsp(tag, p, pg, st, uns, nt);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NPAGE; i++) begin
      m_map[i] = '0; m_wr[i] = '0; m_pnd[i] = '0;
      m_st[i] = 0; m_uns[i] = 1'b0; m_cnt[i] = 0;
    end
    void'($urandom(32'd20240601));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid idle", rsp_valid, 0);
    chk("R1 ready idle", req_ready, 0);
    do_req("R1 R2 first read", 0, 0, 0);

    // immediate mode, page 1: notices, repeat count, unsafe
    do_req("R2 read", 0, 1, 0);
    do_req("R2 second reader", 1, 1, 0);
    do_req("R4 write on shared", 2, 1, 1);
    do_req("R6 write on weak", 2, 1, 1);
    do_req("R6 read on weak", 3, 1, 0);
    do_req("R8 unmap last writer", 2, 1, 3);
    do_req("R4 second weak", 0, 1, 1);
    do_req("R8 unmap to shared", 0, 1, 3);
    do_req("R5 turn unsafe", 1, 1, 1);
    do_req("R8 unmap", 1, 1, 3);
    do_req("R8 unmap to uncached R5 sticky", 3, 1, 3);
    do_req("R3 write alone", 0, 1, 1);
    do_req("R5 unsafe silent", 1, 1, 0);
    chk("R5 silent notice", rsp_notice, 0);

    // page 2: read fault on a dirty page
    do_req("R3 write fresh page", 3, 2, 1);
    chk("R3 dirty code", rsp_state, 2);
    do_req("R4 read on dirty", 1, 2, 0);
    chk("R4 notice to owner", rsp_notice, 4'b1000);

    // delayed mode
    delay_mode = 1'b1;
    do_req("R7 reader a", 0, 4, 0);
    do_req("R7 reader b", 1, 4, 0);
    do_req("R7 delayed write", 1, 4, 1);
    chk("R7 still shared", rsp_state, 1);
    do_req("R7 release not pending", 2, 4, 2);
    do_req("R7 release applies", 1, 4, 2);
    chk("R7 notice at release", rsp_notice, 4'b0001);
    do_req("R3 delayed alone", 0, 5, 0);
    do_req("R3 delayed alone write", 0, 5, 1);
    do_req("R7 reader", 0, 6, 0);
    do_req("R7 reader", 1, 6, 0);
    do_req("R7 pending writer", 0, 6, 1);
    do_req("R8 unmap leaves writer", 1, 6, 3);
    chk("R8 dirty after unmap", rsp_state, 2);
    delay_mode = 1'b0;

    // same-page collision
    begin
      int w, o, st, nt;
      bit uns;
      @(negedge clk);
      drive(0, 3, 0);
      drive(1, 3, 0);
      #1;
      w = rr_pick(4'b0011);
      o = (w == 0) ? 1 : 0;
      chk("R9 single grant", req_ready, 1 << w);
      @(posedge clk);
      #1;
      req_valid[w] = 1'b0;
      last_gnt = w;
      model_apply(w, 3, 0, st, uns, nt);
      @(negedge clk);
      #1;
      chk("R10 same page held", req_ready[o], 0);
      @(posedge clk);
      @(negedge clk);
      #1;
      chk("R10 released next cycle", req_ready[o], 1);
      @(posedge clk);
      #1;
      req_valid[o] = 1'b0;
      last_gnt = o;
      @(negedge clk);
      check_rsp("R10 first in order", w, 3, st, uns, nt);
      model_apply(o, 3, 0, st, uns, nt);
      @(posedge clk);
      @(negedge clk);
      chk("R10 gap", rsp_valid, 0);
      @(posedge clk);
      @(negedge clk);
      check_rsp("R10 second in order", o, 3, st, uns, nt);
    end

    // different pages proceed back to back
    begin
      int w, o, st1, nt1, st2, nt2;
      bit uns1, uns2;
      @(negedge clk);
      drive(2, 7, 1);
      drive(3, 8, 0);
      #1;
      w = rr_pick(4'b1100);
      o = (w == 2) ? 3 : 2;
      chk("R9 grant rotation", req_ready, 1 << w);
      @(posedge clk);
      #1;
      req_valid[w] = 1'b0;
      last_gnt = w;
      model_apply(w, (w == 2) ? 7 : 8, (w == 2) ? 1 : 0, st1, uns1, nt1);
      @(negedge clk);
      #1;
      chk("R10 other page not held", req_ready[o], 1);
      @(posedge clk);
      #1;
      req_valid[o] = 1'b0;
      last_gnt = o;
      model_apply(o, (o == 2) ? 7 : 8, (o == 2) ? 1 : 0, st2, uns2, nt2);
      @(posedge clk);
      @(negedge clk);
      check_rsp("R10 back to back a", w, (w == 2) ? 7 : 8, st1, uns1, nt1);
      @(posedge clk);
      @(negedge clk);
      check_rsp("R10 back to back b", o, (o == 2) ? 7 : 8, st2, uns2, nt2);
    end

    // all ports at once: rotation order
    begin
      bit [NPROC-1:0] pendm;
      int st, nt;
      bit uns;
      @(negedge clk);
      for (int i = 0; i < NPROC; i++) drive(i, 8 + i, 0);
      pendm = '1;
      for (int n = 0; n < NPROC; n++) begin
        int w;
        #1;
        w = rr_pick(pendm);
        chk("R9 round robin order", req_ready, 1 << w);
        @(posedge clk);
        #1;
        req_valid[w] = 1'b0;
        pendm[w] = 1'b0;
        last_gnt = w;
        model_apply(w, 8 + w, 0, st, uns, nt);
        @(negedge clk);
      end
      repeat (4) @(posedge clk);
    end

    // constrained random, one request in flight
    for (int n = 0; n < 300; n++) begin
      int p, pg, op;
      string tag;
      if (n % 60 == 0) delay_mode = $urandom % 2;
      p  = $urandom % NPROC;
      pg = 12 + ($urandom % 4);
      op = $urandom % 4;
      case (op)
        0: tag = "random R2";
        1: tag = "random R4";
        2: tag = "random R7";
        default: tag = "random R8";
      endcase
      do_req(tag, p, pg, op);
    end

    finish_run();
  end
endmodule